// File: doc/BRIEF.md
# Clock Key Controller

This block turns three push keys on a digital clock into clean control events. A mode key steps the clock through three operating states: normal running, alarm setting and time setting. A select key picks whether the hour field or the minute field is the one being adjusted, and two indicator LEDs show that choice. An adjust key increments the selected field. A short press adds exactly one. A hold that lasts long enough switches to a fast automatic repeat.

The block emits four single-cycle increment strobes, one for each of clock hour, clock minute, alarm hour and alarm minute. The BCD counters that receive these strobes sit outside the block. In the running state a long hold of the select key raises a seconds-clear request. The seconds counter outside the block uses this request to stay at zero without carrying into the minutes, so the time can be started on an exact second.

All keys are active low. Each key is synchronised to the system clock, debounced, and edge-detected inside the block. Two parameterised dividers produce the slow hold-sampling tick and the fast repeat tick.

Top module: `clkkey_ctrl`

## Requirements
- R1: After reset the operating state is running (0). Each debounced press of the mode key advances it 0 → 1 → 2 → 0, where 0 is running, 1 is alarm setting and 2 is time setting.
- R2: After reset the selected field is hours. Each debounced press of the select key toggles it between hours and minutes, in every state.
- R3: In states 1 and 2, `led_hour` is high when hours are selected and `led_min` is high when minutes are selected. In state 0 both are low. The two LEDs are never high together.
- R4: In state 2, adjust increments appear only on `clk_hr_inc` (hours selected) or `clk_min_inc` (minutes selected).
- R5: In state 1, adjust increments appear only on `alm_hr_inc` (hours selected) or `alm_min_inc` (minutes selected).
- R6: In state 0 no increment strobe is produced. In any state at most one strobe is high in a cycle.
- R7: An adjust press released before HOLD_TICKS slow ticks have been seen while the key is held gives exactly one increment.
- R8: Once the adjust key has been held across HOLD_TICKS slow ticks, one increment is emitted per fast tick until the key is released. No further increments follow the release.
- R9: In state 0, `sec_clr` goes high after the select key has been held across HOLD_TICKS slow ticks, and it falls after the key is released. In states 1 and 2 `sec_clr` stays low.
- R10: A key low pulse shorter than DEB_LEN consecutive system clocks is ignored and produces no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_key_n | input | 1 | Mode key, active low |
| sel_key_n | input | 1 | Field select key, active low |
| adj_key_n | input | 1 | Adjust key, active low |
| led_hour | output | 1 | Hour field selected indicator |
| led_min | output | 1 | Minute field selected indicator |
| clk_hr_inc | output | 1 | Clock hour increment strobe |
| clk_min_inc | output | 1 | Clock minute increment strobe |
| alm_hr_inc | output | 1 | Alarm hour increment strobe |
| alm_min_inc | output | 1 | Alarm minute increment strobe |
| sec_clr | output | 1 | Seconds clear request (running state only) |

## Verification
The embedded properties check on every cycle that the state value never leaves its three legal codes and only moves in its fixed order. They also check that strobes are mutually exclusive, that the current state gates which strobes and which seconds-clear request can appear, and that the LEDs never both light. The exact strobe counts depend on key timing: one increment per short press, a burst bounded by the fast rate for a long hold, silence after release, and glitch rejection. The seconds-clear response to a long select hold also depends on key timing. Only the bench's press scenarios, driven in each state and for each field, can show these.

// File: rtl/clkkey_pkg.sv
package clkkey_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_ALARM = 2'd1,
    MODE_SET   = 2'd2
  } mode_e;

  typedef enum logic {
    TGT_HOUR = 1'b0,
    TGT_MIN  = 1'b1
  } tgt_e;

  localparam int KEY_MODE = 0;
  localparam int KEY_SEL  = 1;
  localparam int KEY_ADJ  = 2;
  localparam int NUM_KEYS = 3;

  function automatic mode_e mode_step(mode_e m);
    case (m)
      MODE_RUN:   return MODE_ALARM;
      MODE_ALARM: return MODE_SET;
      default:    return MODE_RUN;
    endcase
  endfunction

endpackage

// File: rtl/clkkey_filter.sv
module clkkey_filter #(
  parameter int DEB_LEN = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_n,
  output logic held,
  output logic press
);

  localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_LEN - 1);

  logic          sync1_q, sync2_q;
  logic          stable_q, stable_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          press_q, press_d;

  // two-flop synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= key_n;
      sync2_q <= sync1_q;
    end
  end

  // debounce: accept a new level only after DEB_LEN agreeing samples
  always_comb begin
    stable_d = stable_q;
    cnt_d    = '0;
    if (sync2_q != stable_q) begin
      if (cnt_q == CNT_LAST) begin
        stable_d = sync2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    press_d = stable_q & ~stable_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_q <= 1'b1;
      cnt_q    <= '0;
      press_q  <= 1'b0;
    end else begin
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
      press_q  <= press_d;
    end
  end

  assign held  = ~stable_q;
  assign press = press_q;

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    press |=> !press); // R7

  AST_DEB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R10

endmodule

// File: rtl/clkkey_div.sv
module clkkey_div #(
  parameter int DIV = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    tick_d = (cnt_q == CNT_LAST);
    cnt_d  = tick_d ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R8

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick); // R8

endmodule

// File: rtl/clkkey_hold.sv
module clkkey_hold #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic held,
  input  logic tick,
  output logic long_hold
);

  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;

  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    if (!held) begin
      cnt_d  = '0;
      long_d = 1'b0;
    end else if (tick && !long_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        long_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end

  assign long_hold = long_q;

  AST_LONG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !held |=> !long_hold); // R8

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX); // R8

  AST_LONG_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_hold) |-> cnt_q == CNT_MAX); // R8

endmodule

// File: rtl/clkkey_ctrl.sv
module clkkey_ctrl
  import clkkey_pkg::*;
#(
  parameter int DEB_LEN    = 500_000,
  parameter int TICK_DIV   = 12_500_000,
  parameter int REP_DIV    = 5_000_000,
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_key_n,
  input  logic sel_key_n,
  input  logic adj_key_n,
  output logic led_hour,
  output logic led_min,
  output logic clk_hr_inc,
  output logic clk_min_inc,
  output logic alm_hr_inc,
  output logic alm_min_inc,
  output logic sec_clr
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // key conditioning
  logic [NUM_KEYS-1:0] key_n_vec;
  logic [NUM_KEYS-1:0] key_held;
  logic [NUM_KEYS-1:0] key_press;

  assign key_n_vec[KEY_MODE] = mode_key_n;
  assign key_n_vec[KEY_SEL]  = sel_key_n;
  assign key_n_vec[KEY_ADJ]  = adj_key_n;

  for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_key
    clkkey_filter #(.DEB_LEN(DEB_LEN)) u_filter (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .key_n (key_n_vec[gi]),
      .held  (key_held[gi]),
      .press (key_press[gi])
    );

    AST_PRESS_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      key_press[gi] |-> key_held[gi]); // R10
  end

  // timebases
  logic slow_tick, fast_tick;

  clkkey_div #(.DIV(TICK_DIV)) u_slow_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (slow_tick)
  );

  clkkey_div #(.DIV(REP_DIV)) u_fast_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (fast_tick)
  );

  // hold detection for adjust and select keys
  logic adj_long, sel_long;

  clkkey_hold #(.HOLD_TICKS(HOLD_TICKS)) u_adj_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .held      (key_held[KEY_ADJ]),
    .tick      (slow_tick),
    .long_hold (adj_long)
  );

  clkkey_hold #(.HOLD_TICKS(HOLD_TICKS)) u_sel_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .held      (key_held[KEY_SEL]),
    .tick      (slow_tick),
    .long_hold (sel_long)
  );

  // state, target and strobe registers
  mode_e mode_q, mode_d;
  tgt_e  tgt_q, tgt_d;
  logic  inc_any;
  logic  clk_hr_q, clk_hr_d, clk_min_q, clk_min_d;
  logic  alm_hr_q, alm_hr_d, alm_min_q, alm_min_d;
  logic  sec_clr_q, sec_clr_d;

  always_comb begin
    mode_d = mode_q;
    if (key_press[KEY_MODE]) begin
      mode_d = mode_step(mode_q);
    end
    tgt_d = tgt_q;
    if (key_press[KEY_SEL]) begin
      tgt_d = (tgt_q == TGT_HOUR) ? TGT_MIN : TGT_HOUR;
    end

    inc_any   = key_press[KEY_ADJ] | (adj_long & fast_tick);
    clk_hr_d  = inc_any && (mode_q == MODE_SET)   && (tgt_q == TGT_HOUR);
    clk_min_d = inc_any && (mode_q == MODE_SET)   && (tgt_q == TGT_MIN);
    alm_hr_d  = inc_any && (mode_q == MODE_ALARM) && (tgt_q == TGT_HOUR);
    alm_min_d = inc_any && (mode_q == MODE_ALARM) && (tgt_q == TGT_MIN);
    sec_clr_d = sel_long && (mode_q == MODE_RUN);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q    <= MODE_RUN;
      tgt_q     <= TGT_HOUR;
      clk_hr_q  <= 1'b0;
      clk_min_q <= 1'b0;
      alm_hr_q  <= 1'b0;
      alm_min_q <= 1'b0;
      sec_clr_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      tgt_q     <= tgt_d;
      clk_hr_q  <= clk_hr_d;
      clk_min_q <= clk_min_d;
      alm_hr_q  <= alm_hr_d;
      alm_min_q <= alm_min_d;
      sec_clr_q <= sec_clr_d;
    end
  end

  assign led_hour    = (mode_q != MODE_RUN) && (tgt_q == TGT_HOUR);
  assign led_min     = (mode_q != MODE_RUN) && (tgt_q == TGT_MIN);
  assign clk_hr_inc  = clk_hr_q;
  assign clk_min_inc = clk_min_q;
  assign alm_hr_inc  = alm_hr_q;
  assign alm_min_inc = alm_min_q;
  assign sec_clr     = sec_clr_q;

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q != 2'd3); // R1

  AST_MODE_ORDER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(mode_q) |-> mode_q == mode_step($past(mode_q))); // R1

  AST_LED_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(led_hour && led_min)); // R3

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({clk_hr_inc, clk_min_inc, alm_hr_inc, alm_min_inc})); // R6

  AST_RUN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == MODE_RUN) |=> !(clk_hr_inc || clk_min_inc || alm_hr_inc || alm_min_inc)); // R6

  AST_SET_ROUTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == MODE_SET) |=> !(alm_hr_inc || alm_min_inc)); // R4

  AST_ALARM_ROUTE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == MODE_ALARM) |=> !(clk_hr_inc || clk_min_inc)); // R5

  AST_SECCLR_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q != MODE_RUN) |=> !sec_clr); // R9

endmodule

// File: tb/clkkey_ctrl_test.sv
module clkkey_ctrl_test;

  localparam int DEB  = 4;
  localparam int TICK = 40;
  localparam int REP  = 8;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_key_n = 1'b1, sel_key_n = 1'b1, adj_key_n = 1'b1;
  logic led_hour, led_min, clk_hr_inc, clk_min_inc, alm_hr_inc, alm_min_inc, sec_clr;

  always #2.5 clk = ~clk;

  clkkey_ctrl #(.DEB_LEN(DEB), .TICK_DIV(TICK), .REP_DIV(REP), .HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rst_n(rst_n),
    .mode_key_n(mode_key_n), .sel_key_n(sel_key_n), .adj_key_n(adj_key_n),
    .led_hour(led_hour), .led_min(led_min),
    .clk_hr_inc(clk_hr_inc), .clk_min_inc(clk_min_inc),
    .alm_hr_inc(alm_hr_inc), .alm_min_inc(alm_min_inc),
    .sec_clr(sec_clr)
  );

  int checks = 0;
  int fails  = 0;
  int cnt [4];
  int exp_mode = 0;
  int exp_tgt  = 0;

  initial for (int i = 0; i < 4; i++) cnt[i] = 0;

  always @(negedge clk) begin
    if (clk_hr_inc)  cnt[0] = cnt[0] + 1;
    if (clk_min_inc) cnt[1] = cnt[1] + 1;
    if (alm_hr_inc)  cnt[2] = cnt[2] + 1;
    if (alm_min_inc) cnt[3] = cnt[3] + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // strobe index for a state/field pair, -1 when no strobe is expected
  function automatic int route_idx(input int m, input int t);
    if (m == 2) return t;
    if (m == 1) return 2 + t;
    return -1;
  endfunction

  function automatic int exp_led_h(input int m, input int t);
    return (m != 0 && t == 0) ? 1 : 0;
  endfunction

  function automatic int exp_led_m(input int m, input int t);
    return (m != 0 && t == 1) ? 1 : 0;
  endfunction

  task automatic drive_key(input int k, input int low_cycles);
    @(negedge clk);
    case (k)
      0: mode_key_n = 1'b0;
      1: sel_key_n  = 1'b0;
      default: adj_key_n = 1'b0;
    endcase
    repeat (low_cycles) @(negedge clk);
    mode_key_n = 1'b1;
    sel_key_n  = 1'b1;
    adj_key_n  = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic check_leds(input string req);
    check(led_hour == exp_led_h(exp_mode, exp_tgt), req, led_hour, exp_led_h(exp_mode, exp_tgt));
    check(led_min == exp_led_m(exp_mode, exp_tgt), req, led_min, exp_led_m(exp_mode, exp_tgt));
  endtask

  task automatic press_mode();
    drive_key(0, 20);
    exp_mode = (exp_mode == 2) ? 0 : exp_mode + 1;
    check_leds("R1 mode step");
  endtask

  task automatic press_sel(input int dur);
    drive_key(1, dur);
    exp_tgt = 1 - exp_tgt;
    check_leds("R2/R3 select toggle");
  endtask

  task automatic goto_mode(input int m);
    while (exp_mode != m) press_mode();
  endtask

  // adjust press: kind 0 short, 1 long, 2 glitch
  task automatic adj_check(input int kind, input int dur);
    int base [4];
    int idx;
    int d;
    for (int i = 0; i < 4; i++) base[i] = cnt[i];
    drive_key(2, dur);
    idx = route_idx(exp_mode, exp_tgt);
    for (int i = 0; i < 4; i++) begin
      d = cnt[i] - base[i];
      if (kind == 2 || i != idx) begin
        check(d == 0, (kind == 2) ? "R10 glitch ignored" :
                      (exp_mode == 0) ? "R6 no strobe in running" :
                      (exp_mode == 1) ? "R5 alarm routing" : "R4 set routing", d, 0);
      end else if (kind == 0) begin
        check(d == 1, "R7 single increment", d, 1);
      end else begin
        check(d >= 40 && d <= 2 + dur / REP, "R8 repeat burst", d, dur / REP);
      end
    end
    if (kind == 1) begin
      for (int i = 0; i < 4; i++) base[i] = cnt[i];
      repeat (80) @(negedge clk);
      d = 0;
      for (int i = 0; i < 4; i++) d += cnt[i] - base[i];
      check(d == 0, "R8 silent after release", d, 0);
    end
  endtask

  task automatic secclr_check(input int expv, input string req);
    @(negedge clk);
    sel_key_n = 1'b0;
    repeat (250) @(negedge clk);
    check(sec_clr == expv[0], req, sec_clr, expv);
    sel_key_n = 1'b1;
    repeat (40) @(negedge clk);
    exp_tgt = 1 - exp_tgt;
    check(sec_clr == 1'b0, "R9 clear falls after release", sec_clr, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // reset state
    check_leds("R1/R2/R3 reset");
    check(sec_clr == 1'b0, "R9 reset", sec_clr, 0);
    check({clk_hr_inc, clk_min_inc, alm_hr_inc, alm_min_inc} == 4'b0, "R6 reset strobes", 0, 0);

    // directed corner cases
    adj_check(0, 20);                 // running: nothing
    press_mode(); press_mode(); press_mode(); press_mode();
    goto_mode(2);
    adj_check(0, 20);                 // clock hour
    adj_check(1, 600);                // clock hour repeat
    adj_check(2, 2);                  // glitch
    press_sel(20);
    adj_check(0, 20);                 // clock minute
    goto_mode(1);
    adj_check(1, 600);                // alarm minute repeat
    press_sel(20);
    adj_check(0, 30);                 // alarm hour
    goto_mode(0);
    adj_check(1, 400);                // running long hold: nothing
    secclr_check(1, "R9 clear in running");
    goto_mode(2);
    secclr_check(0, "R9 no clear in setting");
    check_leds("R3 after select hold");

    // random mix
    for (int it = 0; it < 60; it++) begin
      r = int'($urandom % 4);
      case (r)
        0: press_mode();
        1: press_sel(10 + int'($urandom % 30));
        2: adj_check(0, 10 + int'($urandom % 30));
        default: adj_check(2, 1 + int'($urandom % 2));
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule